// File: doc/BRIEF.md
# Upstream attach and speed negotiator

This block sequences how a USB 2.0 hub attaches to its upstream port after power-up. It keeps the D+ pull-up off until two things are true: a configuration-load-done strobe has been seen, and VBUS is present. It then attaches and waits for the upstream side to hold a bus reset.

When a bus reset is recognised, the block drops back to full speed and asks the transceiver to drive a device chirp-K for a fixed number of microsecond ticks. After that it watches the abstracted line state for the host's alternating K/J chirp. If enough valid pairs arrive in time, the block enters high speed and releases the pull-up. If they do not, it stays at full speed with the pull-up on, and waits for the reset to end.

All timing counts a 1 µs tick input, so the block works at any core clock. Losing VBUS returns it to the detached state at any point.

Top module: `usb_attach_negotiator`

## Requirements
- R1: `pullup_en` stays 0 until a `cfg_done` pulse has been seen after reset, even while `vbus_ok` is 1.
- R2: Once `cfg_done` has been seen, `pullup_en` rises within two clocks of `vbus_ok` being 1. While `vbus_ok` is 0 it stays 0.
- R3: If `vbus_ok` is 0 in any state, `pullup_en`, `chirp_k_drive` and `hs_mode` are all 0 on the next clock. When `vbus_ok` returns, the block re-attaches without a new `cfg_done`.
- R4: When attached at full speed, a bus reset is recognised once `line_state` is SE0 (2'b00) for RESET_US ticks. SE0 lasting fewer ticks starts no chirp.
- R5: On recognising a bus reset, `chirp_k_drive` is 1 for exactly CHIRP_US ticks. During that time `pullup_en` is 1 and `hs_mode` is 0.
- R6: After the device chirp, the host chirp is accepted and `hs_mode` becomes 1 with `pullup_en` 0. This requires PAIRS pairs of K (2'b10) followed by J (2'b01), each segment held for at least SEG_US ticks, completed within HWAIT_US ticks.
- R7: If no valid host chirp completes within HWAIT_US ticks, the block stays at full speed (`hs_mode` 0, `pullup_en` 1). K/J segments shorter than SEG_US ticks do not count. A host chirp arriving after the fallback does not enter high speed.
- R8: In high speed, SE0 held for HS_RESET_US ticks is a new bus reset. It restores full speed (`hs_mode` 0, `pullup_en` 1) and starts a new device chirp. Shorter SE0 keeps high speed.
- R9: After a full-speed fallback, no new bus reset is recognised until `line_state` has left SE0.

Parameter defaults: RESET_US=3, HS_RESET_US=3100, CHIRP_US=2000, HWAIT_US=1000, SEG_US=3, PAIRS=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | One-cycle strobe: configuration load finished |
| vbus_ok | input | 1 | Upstream VBUS sensed present |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| line_state | input | 2 | Upstream line: 00 SE0, 01 J, 10 K |
| pullup_en | output | 1 | Enable the D+ pull-up |
| chirp_k_drive | output | 1 | Request the transmitter to drive chirp-K |
| hs_mode | output | 1 | 1 = high speed, 0 = full speed |

## Verification
- **Timing of results:**
  - The line input is registered once, so a line change starts the run counter one clock later.
  - A duration threshold reached on a tick changes the state, and with it the outputs, two clocks after that tick. Host chirp acceptance is an exception: it takes three clocks, because the segment counter adds a register.
  - A VBUS loss shows one clock after it is applied.
- **How the bench keeps to this:**
  - The bench generates ticks itself, one every four clocks.
  - It samples on falling edges three clocks after each tick, which is after the latest possible response.
  - Every threshold is checked twice: one tick short, where the output must not yet have moved, and exactly at the threshold.

// File: rtl/usb_attach_negotiator.sv
module usb_attach_negotiator #(
  parameter int RESET_US    = 3,
  parameter int HS_RESET_US = 3100,
  parameter int CHIRP_US    = 2000,
  parameter int HWAIT_US    = 1000,
  parameter int SEG_US      = 3,
  parameter int PAIRS       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_done,
  input  logic       vbus_ok,
  input  logic       tick_us,
  input  logic [1:0] line_state,
  output logic       pullup_en,
  output logic       chirp_k_drive,
  output logic       hs_mode
);
  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;
  localparam int M1   = (HS_RESET_US > CHIRP_US) ? HS_RESET_US : CHIRP_US;
  localparam int M2   = (M1 > HWAIT_US) ? M1 : HWAIT_US;
  localparam int M3   = (M2 > RESET_US) ? M2 : RESET_US;
  localparam int MAXV = (M3 > SEG_US) ? M3 : SEG_US;
  localparam int TW   = $clog2(MAXV + 2);
  localparam int NSEG = 2 * PAIRS;
  localparam int SW   = $clog2(NSEG + 1);

  typedef enum logic [2:0] {
    S_DETACH, S_ATTACH, S_CHIRP, S_HWAIT, S_RSTEND, S_FS, S_HS
  } st_t;

  st_t           st;
  logic          cfg_seen;
  logic [1:0]    line_q;
  logic [TW-1:0] run_cnt;
  logic [TW-1:0] tmr;
  logic [SW-1:0] seg_cnt;
  logic          seg_ok;
  logic          expect_k;

  wire line_chg = line_state != line_q;
  wire se0_q    = line_q == LS_SE0;
  wire reset_fs = se0_q && (run_cnt >= TW'(RESET_US));
  wire reset_hs = se0_q && (run_cnt >= TW'(HS_RESET_US));
  wire [1:0] seg_want = expect_k ? LS_K : LS_J;
  wire [1:0] seg_next = expect_k ? LS_J : LS_K;

  assign pullup_en     = (st == S_ATTACH) || (st == S_CHIRP) || (st == S_HWAIT) ||
                         (st == S_RSTEND) || (st == S_FS);
  assign chirp_k_drive = st == S_CHIRP;
  assign hs_mode       = st == S_HS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_DETACH;
      cfg_seen <= 1'b0;
      line_q   <= LS_SE0;
      run_cnt  <= '0;
      tmr      <= '0;
      seg_cnt  <= '0;
      seg_ok   <= 1'b0;
      expect_k <= 1'b1;
    end else begin
      if (cfg_done) cfg_seen <= 1'b1;
      line_q <= line_state;
      if (line_chg) run_cnt <= '0;
      else if (tick_us && !(&run_cnt)) run_cnt <= run_cnt + 1'b1;
      if (tick_us && !(&tmr)) tmr <= tmr + 1'b1;

      if (!vbus_ok) begin
        st <= S_DETACH;
      end else begin
        case (st)
          S_DETACH: if (cfg_seen) st <= S_ATTACH;
          S_ATTACH, S_FS: if (reset_fs) begin
            st  <= S_CHIRP;
            tmr <= '0;
          end
          S_HS: if (reset_hs) begin
            st  <= S_CHIRP;
            tmr <= '0;
          end
          S_CHIRP: if (tmr >= TW'(CHIRP_US)) begin
            st       <= S_HWAIT;
            tmr      <= '0;
            run_cnt  <= '0;
            seg_cnt  <= '0;
            seg_ok   <= 1'b0;
            expect_k <= 1'b1;
          end
          S_HWAIT: begin
            if (seg_cnt == SW'(NSEG)) st <= S_HS;
            else if (tmr >= TW'(HWAIT_US)) st <= S_RSTEND;
            else if (line_chg) begin
              if (seg_ok && line_state == seg_next) begin
                expect_k <= !expect_k;
                seg_ok   <= 1'b0;
              end else begin
                seg_cnt  <= '0;
                seg_ok   <= 1'b0;
                expect_k <= 1'b1;
              end
            end else if (!seg_ok && line_q == seg_want && run_cnt >= TW'(SEG_US)) begin
              seg_ok  <= 1'b1;
              seg_cnt <= seg_cnt + 1'b1;
            end
          end
          S_RSTEND: if (!se0_q) st <= S_FS;
          default: st <= S_DETACH;
        endcase
      end
    end
  end

  a_r1_no_pullup_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_seen |-> !pullup_en);

  a_r3_vbus_loss_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_ok |=> (!pullup_en && !chirp_k_drive && !hs_mode));

  a_r2_attach_needs_vbus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pullup_en) |-> $past(vbus_ok));

  a_r5_chirp_on_se0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chirp_k_drive) |-> $past(line_q == LS_SE0));

  a_r6_hs_only_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(st == S_HWAIT));

  a_r9_no_chirp_from_rstend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chirp_k_drive) |-> $past(st != S_RSTEND));
endmodule

// File: tb/sim_usb_attach_negotiator.sv
module sim_usb_attach_negotiator;
  localparam int RESET_US = 3, HS_RESET_US = 3100, CHIRP_US = 2000;
  localparam int HWAIT_US = 1000, SEG_US = 3, PAIRS = 3;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cfg_done = 1'b0, vbus_ok = 1'b0, tick_us = 1'b0;
  logic [1:0] line_state = J;
  logic pullup_en, chirp_k_drive, hs_mode;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  usb_attach_negotiator u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .vbus_ok(vbus_ok),
    .tick_us(tick_us), .line_state(line_state), .pullup_en(pullup_en),
    .chirp_k_drive(chirp_k_drive), .hs_mode(hs_mode));

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
      cyc(2);
    end
  endtask

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s {pullup,chirp,hs} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {pullup_en, chirp_k_drive, hs_mode};
  endfunction

  task automatic t_attach();
    vbus_ok = 1'b1;
    cyc(3);
    chk("R1 in reset", outs(), 3'b000);
    rst_n = 1'b1;
    cyc(10);
    chk("R1 vbus high without cfg", outs(), 3'b000);
    vbus_ok = 1'b0;
    cfg_done = 1'b1;
    cyc(1);
    cfg_done = 1'b0;
    cyc(5);
    chk("R2 cfg seen, vbus low", outs(), 3'b000);
    vbus_ok = 1'b1;
    cyc(2);
    chk("R2 attach on vbus", outs(), 3'b100);
  endtask

  task automatic t_short_se0();
    line_state = SE0;
    ticks(RESET_US - 1);
    chk("R4 se0 one tick short", outs(), 3'b100);
    line_state = J;
    ticks(6);
    chk("R4 short se0 ignored", outs(), 3'b100);
  endtask

  task automatic t_fs_fallback();
    line_state = SE0;
    ticks(RESET_US - 1);
    chk("R4 before threshold", outs(), 3'b100);
    ticks(1);
    chk("R4 reset seen, R5 chirp on", outs(), 3'b110);
    ticks(CHIRP_US - 1);
    chk("R5 chirp still on", outs(), 3'b110);
    ticks(1);
    chk("R5 chirp ends", outs(), 3'b100);
    for (int i = 0; i < PAIRS; i++) begin
      line_state = K;
      ticks(SEG_US - 1);
      line_state = J;
      ticks(SEG_US - 1);
    end
    line_state = SE0;
    ticks(HWAIT_US - 2 * PAIRS * (SEG_US - 1));
    chk("R7 short segments, fallback", outs(), 3'b100);
    ticks(RESET_US + 3);
    chk("R9 no reset while se0 continues", outs(), 3'b100);
    line_state = J;
    ticks(2);
    for (int i = 0; i < PAIRS; i++) begin
      line_state = K;
      ticks(SEG_US);
      line_state = J;
      ticks(SEG_US);
    end
    chk("R7 late host chirp ignored", outs(), 3'b100);
  endtask

  task automatic t_hs_path();
    line_state = SE0;
    ticks(RESET_US);
    chk("R5 chirp for hs attempt", outs(), 3'b110);
    ticks(CHIRP_US);
    chk("R6 waiting for host", outs(), 3'b100);
    for (int i = 0; i < PAIRS; i++) begin
      line_state = K;
      ticks(SEG_US);
      line_state = J;
      if (i == PAIRS - 1) begin
        ticks(SEG_US - 1);
        chk("R6 last segment one tick short", outs(), 3'b100);
        ticks(1);
      end else begin
        ticks(SEG_US);
      end
    end
    chk("R6 high speed, pullup released", outs(), 3'b001);
  endtask

  task automatic t_hs_reset();
    line_state = SE0;
    ticks(HS_RESET_US - 1);
    chk("R8 hs kept under threshold", outs(), 3'b001);
    ticks(1);
    chk("R8 reset from hs", outs(), 3'b110);
  endtask

  task automatic t_vbus_drop();
    vbus_ok = 1'b0;
    cyc(1);
    chk("R3 vbus loss during chirp", outs(), 3'b000);
    line_state = J;
    cyc(10);
    vbus_ok = 1'b1;
    cyc(2);
    chk("R3 reattach without cfg", outs(), 3'b100);
  endtask

  initial begin
    t_attach();
    t_short_se0();
    t_fs_fallback();
    t_hs_path();
    t_hs_reset();
    t_vbus_drop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule